// File: doc/BRIEF.md
# Double-Precision Shifter with Selectable Flag Behaviour

This unit shifts a destination operand and a source operand together as one double-length value and returns the new destination with an updated status flags word. In a left shift, the destination moves toward its MSB and the top bits of the source fill the vacated low bits. In a right shift, the destination moves toward its LSB and the low bits of the source fill the vacated high bits. The operand width is 16, 32 or 64 bits. The shift count is reduced modulo the width.

Overflow and auxiliary carry are not pinned down by the instruction definition for counts above one. A two-bit select picks how they are produced. One behaviour takes overflow from the first single-bit step and clears auxiliary carry. The other takes overflow from the final single-bit step and sets auxiliary carry.

A one-cycle start pulse captures the inputs. On the next clock edge the unit presents the result and flags together with a one-cycle valid strobe.

Top module: `dshift_unit`

## Requirements
- R1: A start sampled high at a rising edge produces valid high for exactly one cycle after that edge. Result and flags hold their value until the next start. A synchronous reset drives valid, result and flags to zero.
- R2: The count is masked to width−1. When the masked count is zero, the result equals the width-masked destination and the flags output equals the flags input bit for bit.
- R3: When dir_right is 0 (left shift) with masked count n, the result is (dst << n) | (src >> (W−n)), truncated to W bits.
- R4: When dir_right is 1 (right shift) with masked count n, the result is (dst >> n) | (src << (W−n)), truncated to W bits.
- R5: CF (flags bit 0) is the last destination bit shifted out. That is dst bit W−n for a left shift and dst bit n−1 for a right shift.
- R6: ZF (bit 6) is set when the W-bit result is zero. SF (bit 7) equals result bit W−1. PF (bit 2) is set when result bits 7:0 contain an even number of ones.
- R7: For a nonzero masked count, only bits 0, 2, 4, 6, 7 and 11 of the flags word are rewritten. Every other bit passes from flags_in unchanged.
- R8: When variant is 0, 1 or 3, AF (bit 4) is cleared. OF (bit 11) is dst[W−1] XOR dst[W−2] for a left shift and dst[W−1] XOR src[0] for a right shift.
- R9: When variant is 2, AF is set and OF is the MSB of the value before the final one-bit step XOR result[W−1]. That is dst[W−n] for a left shift. For a right shift it is src[n−2] when n > 1 and dst[W−1] when n = 1.
- R10: width_sel 0 selects 16 bits, 1 selects 32 bits, and 2 or 3 select 64 bits. Operand bits above W are ignored and the result is zero-extended to 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture inputs this edge |
| dir_right | input | 1 | 0 = shift left, 1 = shift right |
| width_sel | input | 2 | Operand width: 0=16, 1=32, 2/3=64 |
| count | input | CNT_W | Raw shift count |
| dst_in | input | 64 | Destination operand |
| src_in | input | 64 | Fill operand |
| flags_in | input | 32 | Incoming flags word |
| variant | input | 2 | Flag behaviour select |
| result | output | 64 | Shifted destination, zero-extended |
| flags_out | output | 32 | Updated flags word |
| valid | output | 1 | One-cycle result strobe |

## Verification
The bench targets counts that mask to zero: 16 at 16 bits, and 0 and 64 at 64 bits. A design that skipped the mask or the zero bypass would corrupt the destination or clear status bits there.

It runs each operation under all four variant codes, with counts of 1 and above. A swapped variant map shows up as an AF or OF mismatch. So does a wrong index for the final step, in particular the n = 1 right-shift special case.

Narrow widths are driven with garbage in the upper operand bits. This exposes leakage of those bits into the fill or into the zero-extension. Flags words with all non-status bits set catch a clear mask that is too wide.

// File: rtl/dshift_pkg.sv
package dshift_pkg;
    localparam int DATA_W    = 64;
    localparam int FLAG_W    = 32;
    localparam int NUM_LANES = 3;
    localparam int LOG_W     = $clog2(DATA_W);

    localparam int BIT_CF = 0;
    localparam int BIT_PF = 2;
    localparam int BIT_AF = 4;
    localparam int BIT_ZF = 6;
    localparam int BIT_SF = 7;
    localparam int BIT_OF = 11;

    localparam logic [FLAG_W-1:0] STATUS_MASK =
        (FLAG_W'(1) << BIT_CF) | (FLAG_W'(1) << BIT_PF) | (FLAG_W'(1) << BIT_AF) |
        (FLAG_W'(1) << BIT_ZF) | (FLAG_W'(1) << BIT_SF) | (FLAG_W'(1) << BIT_OF);

    typedef enum logic [1:0] {
        FLV_NATIVE  = 2'd0,
        FLV_FIRST   = 2'd1,
        FLV_LAST    = 2'd2,
        FLV_NATIVE2 = 2'd3
    } flag_var_e;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] result;
        logic [FLAG_W-1:0] flags;
    } out_st_t;
endpackage

// File: rtl/dshift_lane.sv
module dshift_lane #(
    parameter int W = 16
) (
    input  logic                 dir_right,
    input  logic [$clog2(W)-1:0] n,
    input  logic [W-1:0]         dst,
    input  logic [W-1:0]         src,
    output logic [W-1:0]         res,
    output logic                 cf,
    output logic                 sf,
    output logic                 zf,
    output logic                 pf,
    output logic                 of_first,
    output logic                 of_last
);
    localparam int NW = $clog2(W);
    localparam int AW = NW + 1;

    logic [AW-1:0] n_w;
    logic [AW-1:0] back;
    logic [W-1:0]  out_bits;
    logic [W-1:0]  src_tail;

    always_comb begin
        n_w      = AW'(n);
        back     = AW'(W) - n_w;
        out_bits = '0;
        src_tail = '0;
        if (!dir_right) begin
            res      = (dst << n_w) | (src >> back);
            out_bits = dst >> back;
            cf       = out_bits[0];
            of_first = dst[W-1] ^ dst[W-2];
            of_last  = out_bits[0] ^ res[W-1];
        end else begin
            res      = (dst >> n_w) | (src << back);
            out_bits = dst >> (n_w - AW'(1));
            cf       = out_bits[0];
            of_first = dst[W-1] ^ src[0];
            src_tail = src >> (n_w - AW'(2));
            of_last  = (n_w > AW'(1)) ? (src_tail[0] ^ res[W-1]) : (dst[W-1] ^ res[W-1]);
        end
        sf = res[W-1];
        zf = (res == '0);
        pf = ~^res[7:0];
    end
endmodule

// File: rtl/dshift_flags.sv
module dshift_flags
    import dshift_pkg::*;
(
    input  logic [1:0]        variant,
    input  logic              active,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic              cf,
    input  logic              pf,
    input  logic              zf,
    input  logic              sf,
    input  logic              of_first,
    input  logic              of_last,
    output logic [FLAG_W-1:0] flags_out
);
    always_comb begin
        flags_out = flags_in;
        if (active) begin
            flags_out         = flags_in & ~STATUS_MASK;
            flags_out[BIT_CF] = cf;
            flags_out[BIT_PF] = pf;
            flags_out[BIT_ZF] = zf;
            flags_out[BIT_SF] = sf;
            case (flag_var_e'(variant))
                FLV_LAST: begin
                    flags_out[BIT_OF] = of_last;
                    flags_out[BIT_AF] = 1'b1;
                end
                default: begin
                    flags_out[BIT_OF] = of_first;
                    flags_out[BIT_AF] = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/dshift_unit.sv
module dshift_unit
    import dshift_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dir_right,
    input  logic [1:0]        width_sel,
    input  logic [CNT_W-1:0]  count,
    input  logic [DATA_W-1:0] dst_in,
    input  logic [DATA_W-1:0] src_in,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic [1:0]        variant,
    output logic [DATA_W-1:0] result,
    output logic [FLAG_W-1:0] flags_out,
    output logic              valid
);
    logic [LOG_W-1:0]     cnt_m;
    logic [1:0]           lane_sel;
    logic [DATA_W-1:0]    lane_res [NUM_LANES];
    logic [NUM_LANES-1:0] lane_cf, lane_sf, lane_zf, lane_pf, lane_off, lane_ofl;
    logic [FLAG_W-1:0]    flags_new;
    out_st_t              st_d, st_q;

    // Width decode and count masking
    always_comb begin
        case (width_sel)
            2'd0:    lane_sel = 2'd0;
            2'd1:    lane_sel = 2'd1;
            default: lane_sel = 2'd2;
        endcase
        cnt_m = count[LOG_W-1:0] & LOG_W'((16 << lane_sel) - 1);
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int LW  = 16 << g;
        localparam int LNW = $clog2(LW);
        logic [LW-1:0] lane_out;

        dshift_lane #(.W(LW)) u_lane (
            .dir_right (dir_right),
            .n         (cnt_m[LNW-1:0]),
            .dst       (dst_in[LW-1:0]),
            .src       (src_in[LW-1:0]),
            .res       (lane_out),
            .cf        (lane_cf[g]),
            .sf        (lane_sf[g]),
            .zf        (lane_zf[g]),
            .pf        (lane_pf[g]),
            .of_first  (lane_off[g]),
            .of_last   (lane_ofl[g])
        );
        assign lane_res[g] = DATA_W'(lane_out);
    end

    dshift_flags u_flags (
        .variant   (variant),
        .active    (cnt_m != '0),
        .flags_in  (flags_in),
        .cf        (lane_cf[lane_sel]),
        .pf        (lane_pf[lane_sel]),
        .zf        (lane_zf[lane_sel]),
        .sf        (lane_sf[lane_sel]),
        .of_first  (lane_off[lane_sel]),
        .of_last   (lane_ofl[lane_sel]),
        .flags_out (flags_new)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = start;
        if (start) begin
            st_d.result = lane_res[lane_sel];
            st_d.flags  = flags_new;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign result    = st_q.result;
    assign flags_out = st_q.flags;
    assign valid     = st_q.valid;

    a_r1_valid_after_start: assert property (@(posedge clk) disable iff (rst)
        start |=> valid);
    a_r1_valid_single: assert property (@(posedge clk) disable iff (rst)
        !start |=> !valid);
    a_r2_zero_keeps_flags: assert property (@(posedge clk) disable iff (rst)
        (start && cnt_m == '0) |=> flags_out == $past(flags_in));
    a_r7_other_bits_kept: assert property (@(posedge clk) disable iff (rst)
        start |=> (flags_out & ~STATUS_MASK) == ($past(flags_in) & ~STATUS_MASK));
    a_r8_af_cleared: assert property (@(posedge clk) disable iff (rst)
        (start && variant != 2'd2 && cnt_m != '0) |=> !flags_out[BIT_AF]);
    a_r9_af_set: assert property (@(posedge clk) disable iff (rst)
        (start && variant == 2'd2 && cnt_m != '0) |=> flags_out[BIT_AF]);
    a_r10_zero_ext16: assert property (@(posedge clk) disable iff (rst)
        (start && width_sel == 2'd0) |=> result[DATA_W-1:16] == '0);
    a_r10_zero_ext32: assert property (@(posedge clk) disable iff (rst)
        (start && width_sel == 2'd1) |=> result[DATA_W-1:32] == '0);
endmodule

// File: tb/sim_dshift_unit.sv
module sim_dshift_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        dir_right = 1'b0;
    logic [1:0]  width_sel = 2'd0;
    logic [7:0]  count = '0;
    logic [63:0] dst_in = '0;
    logic [63:0] src_in = '0;
    logic [31:0] flags_in = '0;
    logic [1:0]  variant = '0;
    logic [63:0] result;
    logic [31:0] flags_out;
    logic        valid;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    dshift_unit u0 (
        .clk(clk), .rst(rst), .start(start), .dir_right(dir_right),
        .width_sel(width_sel), .count(count), .dst_in(dst_in), .src_in(src_in),
        .flags_in(flags_in), .variant(variant), .result(result),
        .flags_out(flags_out), .valid(valid)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference from the requirements: step a double-length value bit by bit.
    function automatic void model(input logic dir, input logic [1:0] ws, input logic [7:0] cnt,
                                  input logic [63:0] d_in, input logic [63:0] s_in,
                                  input logic [31:0] fin, input logic [1:0] vs,
                                  output logic [63:0] r, output logic [31:0] fo);
        int w, n;
        logic [63:0]  mask, d, s;
        logic [127:0] pair, pre;
        logic cf, of_f, of_l, before_msb;
        w    = (ws == 2'd0) ? 16 : (ws == 2'd1) ? 32 : 64;
        mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        d    = d_in & mask;
        s    = s_in & mask;
        n    = int'(cnt) % w;
        if (n == 0) begin
            r  = d;
            fo = fin;
            return;
        end
        if (!dir) begin
            pair       = ({64'd0, d} << w) | {64'd0, s};
            pre        = pair << (n - 1);
            r          = 64'((pre << 1) >> w) & mask;
            before_msb = pre[2*w-1];
            cf         = pre[2*w-1];
            of_f       = d[w-1] ^ d[w-2];
        end else begin
            pair       = ({64'd0, s} << w) | {64'd0, d};
            pre        = pair >> (n - 1);
            r          = 64'(pre >> 1) & mask;
            before_msb = pre[w-1];
            cf         = pre[0];
            of_f       = d[w-1] ^ s[0];
        end
        of_l = before_msb ^ r[w-1];
        fo = fin & ~32'h0000_08D5;
        fo[0]  = cf;
        fo[2]  = ~^r[7:0];
        fo[6]  = (r == 64'd0);
        fo[7]  = r[w-1];
        fo[4]  = (vs == 2'd2);
        fo[11] = (vs == 2'd2) ? of_l : of_f;
    endfunction

    task automatic run_vec(string tag, logic dir, logic [1:0] ws, logic [7:0] cnt,
                           logic [63:0] d, logic [63:0] s, logic [31:0] fin, logic [1:0] vs);
        logic [63:0] er;
        logic [31:0] ef;
        @(negedge clk);
        dir_right = dir; width_sel = ws; count = cnt;
        dst_in = d; src_in = s; flags_in = fin; variant = vs;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        model(dir, ws, cnt, d, s, fin, vs, er, ef);
        check({tag, " valid"}, {63'd0, valid}, 64'd1);
        check({tag, " result"}, result, er);
        check({tag, " flags"}, {32'd0, flags_out}, {32'd0, ef});
    endtask

    task automatic test_reset();   // R1
        check("R1 reset valid", {63'd0, valid}, 64'd0);
        check("R1 reset result", result, 64'd0);
        check("R1 reset flags", {32'd0, flags_out}, 64'd0);
    endtask

    task automatic test_valid_pulse();   // R1: one-cycle strobe, outputs hold
        logic [63:0] held;
        run_vec("R1 pulse", 1'b0, 2'd1, 8'd4, 64'h1234_5678, 64'hABCD_0000, 32'h2, 2'd1);
        held = result;
        dst_in = 64'hFFFF; count = 8'd7;
        @(negedge clk);
        check("R1 valid low", {63'd0, valid}, 64'd0);
        check("R1 result held", result, held);
    endtask

    task automatic test_left();   // R3 R5 R6
        run_vec("R3 left16", 1'b0, 2'd0, 8'd4, 64'h0000_0000_0000_8123, 64'h0000_0000_0000_F00D, 32'h0, 2'd1);
        run_vec("R3 left32", 1'b0, 2'd1, 8'd31, 64'h8000_0001, 64'h7FFF_FFFF, 32'h0, 2'd0);
        run_vec("R3 left64", 1'b0, 2'd2, 8'd1, 64'hC000_0000_0000_0001, 64'h8000_0000_0000_0000, 32'h0, 2'd1);
        run_vec("R5 left64 cf", 1'b0, 2'd3, 8'd60, 64'h1F00_0000_0000_0000, 64'h0123_4567_89AB_CDEF, 32'h0, 2'd2);
        run_vec("R6 zero result", 1'b0, 2'd1, 8'd9, 64'h0, 64'h0, 32'h0, 2'd1);
    endtask

    task automatic test_right();  // R4 R5 R6
        run_vec("R4 right16", 1'b1, 2'd0, 8'd3, 64'h0000_0000_0000_0F0F, 64'h0000_0000_0000_0005, 32'h0, 2'd1);
        run_vec("R4 right32", 1'b1, 2'd1, 8'd17, 64'hDEAD_BEEF, 64'h1357_9BDF, 32'h0, 2'd0);
        run_vec("R4 right64", 1'b1, 2'd2, 8'd63, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32'h0, 2'd1);
        run_vec("R5 right cf", 1'b1, 2'd2, 8'd8, 64'h0000_0000_0000_0080, 64'h55, 32'h0, 2'd2);
    endtask

    task automatic test_mask();   // R2
        run_vec("R2 cnt0", 1'b0, 2'd2, 8'd0, 64'h0123_4567_89AB_CDEF, 64'h1, 32'hFFFF_FFFF, 2'd2);
        run_vec("R2 cnt16 w16", 1'b1, 2'd0, 8'd16, 64'hAAAA_BBBB_CCCC_DDDD, 64'h7, 32'h0000_08D5, 2'd1);
        run_vec("R2 cnt64 w64", 1'b0, 2'd2, 8'd64, 64'h8000_0000_0000_0001, 64'h3, 32'h0000_0A44, 2'd0);
        run_vec("R2 cnt35 w32", 1'b0, 2'd1, 8'd35, 64'hF000_000F, 64'hE000_0000, 32'h0, 2'd1);
    endtask

    task automatic test_variants();   // R8 R9
        for (int v = 0; v < 4; v++) begin
            run_vec(v == 2 ? "R9 left n5" : "R8 left n5", 1'b0, 2'd1, 8'd5,
                    64'h4C00_0001, 64'h8000_0000, 32'h0, 2'(v));
            run_vec(v == 2 ? "R9 right n1" : "R8 right n1", 1'b1, 2'd0, 8'd1,
                    64'h0000_0000_0000_8001, 64'h0000_0000_0000_0000, 32'h0, 2'(v));
            run_vec(v == 2 ? "R9 right n6" : "R8 right n6", 1'b1, 2'd2, 8'd6,
                    64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_0010, 32'h0, 2'(v));
            run_vec(v == 2 ? "R9 left n1" : "R8 left n1", 1'b0, 2'd0, 8'd1,
                    64'h0000_0000_0000_4000, 64'h0, 32'h0, 2'(v));
        end
    endtask

    task automatic test_passthrough();   // R7
        run_vec("R7 keep bits", 1'b0, 2'd1, 8'd3, 64'h1234_5678, 64'h9ABC_DEF0, 32'hFFFF_F72A, 2'd2);
        run_vec("R7 keep bits r", 1'b1, 2'd2, 8'd12, 64'hFEDC_BA98_7654_3210, 64'h0F, 32'hA5A5_F72A, 2'd1);
    endtask

    task automatic test_width();   // R10
        run_vec("R10 w16 upper ignored", 1'b0, 2'd0, 8'd8, 64'hFFFF_FFFF_FFFF_1234, 64'hFFFF_FFFF_FFFF_00AB, 32'h0, 2'd1);
        run_vec("R10 w16 right", 1'b1, 2'd0, 8'd8, 64'h5555_5555_5555_1234, 64'hAAAA_AAAA_AAAA_CD00, 32'h0, 2'd2);
        run_vec("R10 w32 upper ignored", 1'b1, 2'd1, 8'd4, 64'hFFFF_FFFF_0000_0010, 64'hFFFF_FFFF_0000_000F, 32'h0, 2'd1);
        run_vec("R10 sel3 is 64", 1'b0, 2'd3, 8'd40, 64'h0000_00FF_0000_0000, 64'hFFFF_0000_0000_0000, 32'h0, 2'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_valid_pulse();
        test_left();
        test_right();
        test_mask();
        test_variants();
        test_passthrough();
        test_width();
        // R1: synchronous reset clears outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        test_reset();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule